// File: doc/BRIEF.md
# Three-line rotating barrier agent

This block is the per-node agent of a barrier synchronizer for a small group of processing elements. The nodes share three open-drain barrier wires, and each wire is tied across all nodes. A wire therefore reads high only when no node pulls it low, which gives a wired-AND. Each node holds one agent. The agent takes a single-cycle arrival request and a membership flag. It drives the node's three control bits, reads back the resolved wire levels and raises a one-cycle completion flag when every participating node has checked in.

The agent holds no set/reset state for the barrier itself. It rotates through the three wires instead. During barrier k it checks in on one wire, leaves the wire of barrier k-1 released so that slower nodes can still see it high, and pulls the wire of barrier k+1 low to prepare it. Two of the control bits are inverted between register value and wire, and the agent corrects this internally. A node that does not participate releases every wire, so it counts as a constant 1 on the AND. It keeps following the phase so that it can join a later barrier.

Top module: `tri_barrier_agent`

## Requirements
- R1: While reset is asserted, and after it until the first arrival, a member agent reports phase 0 and done low. It drives ctl_o = 3'b001: wire 0 pulled, wire 1 pulled, wire 2 released.
- R2: Bit index 1 of ctl_o and fb_i uses true sense (1 = released/high). Indices 0 and 2 are inverted (0 = released/high). ctl_o index i belongs to wire i, and wire i carries the barriers whose phase is i.
- R3: A member at phase p that has not checked in releases wire p-1, pulls wire p and pulls wire p+1 (indices taken modulo 3).
- R4: After an arrival is accepted, the member releases wire p and keeps wire p-1 released and wire p+1 pulled.
- R5: done_o is high for exactly one cycle. It goes high at the second rising edge after wire p rises, when the node has checked in. Every member completes in the same cycle.
- R6: On each completion the phase advances 0, 1, 2, 0.
- R7: No agent completes a barrier before every participating agent has arrived at it.
- R8: A non-member releases all three wires and ignores arrive_i. It never raises done_o and advances its phase with the members.
- R9: An arrival that comes while the agent is waiting is held. At the completion edge the agent checks in on the next wire without a further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| member_i | input | 1 | Node participates in barriers |
| arrive_i | input | 1 | One-cycle arrival request |
| fb_i | input | 3 | Read-back of the resolved wires, register sense |
| ctl_o | output | 3 | Control bits driving the three open-drain wires, register sense |
| done_o | output | 1 | One-cycle barrier completion |
| phase_o | output | 2 | Index of the wire in use for the current barrier |

## Verification
The bench builds four agents with the default inversion mask and resolves the wired-AND of their outputs arithmetically. It sweeps all fifteen non-empty membership sets, each with several arrival-skew patterns. Because the barriers run back to back, every phase, every wire and every inversion is exercised while nodes join and leave between barriers. A directed case makes one node arrive early, while it is still waiting, so that its request is held across a completion.

// File: rtl/tri_barrier_agent.sv
module tri_barrier_agent #(
  parameter logic [2:0] INV_MASK = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       member_i,
  input  logic       arrive_i,
  input  logic [2:0] fb_i,
  output logic [2:0] ctl_o,
  output logic       done_o,
  output logic [1:0] phase_o
);

  logic [1:0] phase_q, phase_nx, phase_pv;
  logic       checked_q, pend_q;
  logic [2:0] sync1_q, sync2_q, rel;
  logic       line_hi;

  assign phase_nx = (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
  assign phase_pv = (phase_q == 2'd0) ? 2'd2 : phase_q - 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= fb_i ^ INV_MASK;
      sync2_q <= sync1_q;
    end
  end

  assign line_hi = sync2_q[phase_q];
  assign done_o  = member_i & checked_q & line_hi;

  always_comb begin
    if (!member_i) begin
      rel = 3'b111;
    end else begin
      rel = 3'b000;
      rel[phase_pv] = 1'b1;
      rel[phase_q]  = checked_q;
    end
  end

  assign ctl_o   = rel ^ INV_MASK;
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 2'd0;
      checked_q <= 1'b0;
      pend_q    <= 1'b0;
    end else if (member_i) begin
      if (done_o) begin
        phase_q   <= phase_nx;
        checked_q <= pend_q | arrive_i;
        pend_q    <= 1'b0;
      end else if (checked_q) begin
        if (arrive_i) pend_q <= 1'b1;
      end else if (arrive_i | pend_q) begin
        checked_q <= 1'b1;
        pend_q    <= 1'b0;
      end
    end else begin
      checked_q <= 1'b0;
      pend_q    <= 1'b0;
      if (line_hi) phase_q <= phase_nx;
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (phase_q == (($past(phase_q) == 2'd2) ? 2'd0 : $past(phase_q) + 2'd1)));

  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  assert_nonmember_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !member_i |-> !done_o);

  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (member_i && checked_q && !done_o) |=> $stable(phase_q));

endmodule

// File: tb/tri_barrier_agent_bench.sv
module tri_barrier_agent_bench;
  localparam logic [2:0] INV = 3'b101;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] member = '1;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] done;
  logic [2:0] ctl [N];
  logic [1:0] phase [N];
  logic [2:0] wire_lv;
  logic [2:0] fb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_ph = 0;
  int dly [N];
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb begin
    wire_lv = 3'b111;
    for (int j = 0; j < N; j++) wire_lv = wire_lv & (ctl[j] ^ INV);
    fb = wire_lv ^ INV;
  end

  for (genvar g = 0; g < N; g++) begin : g_node
    tri_barrier_agent u_tri_barrier_agent (
      .clk(clk), .rst_n(rst_n), .member_i(member[g]), .arrive_i(arrive[g]),
      .fb_i(fb), .ctl_o(ctl[g]), .done_o(done[g]), .phase_o(phase[g]));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_rel(input int ph, input bit in);
    logic [2:0] r;
    r = 3'b000;
    r[(ph + 2) % 3] = 1'b1;
    r[ph] = in;
    return r;
  endfunction

  task automatic run_barrier(input logic [N-1:0] mask, input logic [N-1:0] pre, input int extra);
    int last;
    bit all_in;
    last = 0;
    @(negedge clk);
    member = mask;
    for (int j = 0; j < N; j++) if (mask[j] && !pre[j] && dly[j] > last) last = dly[j];
    for (int t = 0; t <= last + 6; t++) begin
      @(negedge clk);
      all_in = 1;
      for (int j = 0; j < N; j++)
        if (mask[j] && !pre[j] && dly[j] >= t) all_in = 0;
      for (int j = 0; j < N; j++) begin
        bit in;
        in = pre[j] || (dly[j] < t);
        if (mask[j]) begin
          chk(done[j] == (t == last + 3), "R5 done timing", done[j], (t == last + 3));
          if (done[j]) chk(all_in, "R7 early completion", 0, 1);
          if (t <= last + 3) begin
            if (in) chk((ctl[j] ^ INV) == exp_rel(cur_ph, 1'b1), "R4 checked-in drive",
                        ctl[j] ^ INV, exp_rel(cur_ph, 1'b1));
            else    chk((ctl[j] ^ INV) == exp_rel(cur_ph, 1'b0), "R3 waiting drive",
                        ctl[j] ^ INV, exp_rel(cur_ph, 1'b0));
          end
        end else begin
          chk(done[j] == 1'b0, "R8 non-member done", done[j], 0);
          chk((ctl[j] ^ INV) == 3'b111, "R8 non-member release", ctl[j] ^ INV, 7);
        end
      end
      arrive = '0;
      for (int j = 0; j < N; j++) if (!pre[j] && dly[j] == t) arrive[j] = 1'b1;
      if (extra >= 0 && t == last + 1) arrive[extra] = 1'b1;
    end
    arrive = '0;
    cur_ph = (cur_ph + 1) % 3;
    for (int j = 0; j < N; j++)
      chk(phase[j] == 2'(cur_ph), "R6 phase advance", phase[j], cur_ph);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int j = 0; j < N; j++) begin
      chk(ctl[j] == 3'b001, "R1 reset drive", ctl[j], 1);
      chk(phase[j] == 2'd0, "R1 reset phase", phase[j], 0);
      chk(done[j] == 1'b0, "R1 reset done", done[j], 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int j = 0; j < N; j++) chk(ctl[j] == 3'b001, "R1 idle drive", ctl[j], 1);

    for (int j = 0; j < N; j++) dly[j] = j;
    run_barrier(4'b1111, 4'b0000, -1);
    @(negedge clk);
    for (int j = 0; j < N; j++) chk(ctl[j] == 3'b100, "R2 raw bits at phase 1", ctl[j], 4);

    for (int m = 1; m < 16; m++) begin
      for (int rep = 0; rep < 3; rep++) begin
        for (int j = 0; j < N; j++) dly[j] = (m * 3 + j * (rep + 2) + rep * 5) % 7;
        run_barrier(4'(m), 4'b0000, -1);
      end
    end

    for (int j = 0; j < N; j++) dly[j] = 2 + j;
    run_barrier(4'b1111, 4'b0000, 0);
    @(negedge clk);
    chk((ctl[0] ^ INV) == exp_rel(cur_ph, 1'b1), "R9 pending check-in", ctl[0] ^ INV,
        exp_rel(cur_ph, 1'b1));
    chk((ctl[1] ^ INV) == exp_rel(cur_ph, 1'b0), "R9 others wait", ctl[1] ^ INV,
        exp_rel(cur_ph, 1'b0));
    dly[0] = 0; dly[1] = 4; dly[2] = 1; dly[3] = 3;
    run_barrier(4'b1111, 4'b0001, -1);
    for (int j = 0; j < N; j++) dly[j] = 1;
    run_barrier(4'b1111, 4'b0000, -1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule